// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the head of an Ethernet receive path. It decides whether a frame is kept by looking only at the six destination address bytes, which arrive one per strobe at the start of the frame. Software first loads three things through a small word-wide write port: a 48-bit station address, a 64-entry multicast hash table and four accept-mode bits. One cycle after the sixth address byte, the block issues a one-cycle decision strobe. With it come the accept verdict, three classification flags laid out as in the receive status word, and the 6-bit hash index that was used.

Each address falls into one of three classes. It is broadcast when all 48 bits are one. It is multicast when the group bit (bit 0 of the first byte) is set and the address is not broadcast. It is a physical match when it equals the station address. A multicast address is accepted only when its hash bit is set in the table. The hash index is the top six bits of a big-endian CRC-32. This CRC is preset to all ones, fed each byte least significant bit first, and takes no final inversion or reflection. Each class is admitted only when its accept-mode bit is set. A promiscuous bit admits every frame, but the class flags are still reported.

Top module: `raf_rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are 0 and `dec_status` and `dec_hash_idx` are all zeros.
- R2: A write with `cfg_we` high loads the word at `cfg_addr`, and the written value takes effect for the next address. The words are:
  - 0: station address bytes 0..3, byte 0 in bits 7:0.
  - 1: station address bytes 4 and 5, in bits 7:0 and 15:8.
  - 2: hash table bits 31:0.
  - 3: hash table bits 63:32.
  - 4: accept mode, in bits 3:0.

  Writes to addresses 5 to 7 change nothing.
- R3: The CRC register is preset to 0xFFFFFFFF on the first address byte. For each data bit, taken LSB first within each byte, the feedback is CRC bit 31 XOR the data bit. The register then shifts left, and when the feedback is 1 it is XORed with 0x04C11DB7. After six bytes, CRC bits 31:26 form `dec_hash_idx`, and that value selects the hash table bit.
- R4: `dec_valid` is high for exactly the one cycle that follows the clock edge that samples the sixth address byte. `dec_accept`, `dec_status` and `dec_hash_idx` hold their values until the next decision.
- R5: The status flags are: bit 13 for broadcast (all ones), bit 14 for an exact match with the station address, and bit 15 for multicast (group bit set and not broadcast). All other bits of `dec_status` are 0.
- R6: The accept-mode bits are: bit 0 promiscuous, bit 1 physical match, bit 2 multicast, bit 3 broadcast. The frame is accepted when any of the following holds:
  - the promiscuous bit is set;
  - it is a physical match and bit 1 is set;
  - it is multicast, bit 2 is set and the hash bit is set;
  - it is broadcast and bit 3 is set.
- R7: With the promiscuous bit set, every address is accepted, and the R5 flags are still reported.
- R8: A byte marked first always starts a new address, even in the middle of one. Bytes arriving after the sixth, or before any first marker, produce no decision and leave the outputs unchanged.
- R9: Idle cycles (`rx_byte_valid` low) between address bytes are allowed and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| rx_byte_valid | input | 1 | Address byte strobe |
| rx_byte_first | input | 1 | Marks the first destination address byte |
| rx_byte | input | 8 | Destination address byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_status | output | 16 | Class flags in receive status layout |
| dec_hash_idx | output | 6 | Multicast hash index of the last address |

## Verification
The hardest case to reach is a multicast accept that hinges on a single table bit. The port only shows the effect of the CRC through that bit, so the bench computes the hash index of a chosen group address with its own serial CRC model. It then sets only that bit, through the low or high table word as needed, and checks that the same address flips from rejected to accepted. Restarts in mid-address and surplus bytes are reached by driving a truncated address or extra bytes straight into the byte stream, without any other reset.

// File: rtl/raf_pkg.sv
package raf_pkg;

  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_TAIL = 32'h04C1_1DB6;

  // accept-mode bit positions
  localparam int MODE_PROMISC = 0;
  localparam int MODE_PHYS    = 1;
  localparam int MODE_MCAST   = 2;
  localparam int MODE_BCAST   = 3;

  // status flag positions
  localparam int ST_BCAST = 13;
  localparam int ST_PHYS  = 14;
  localparam int ST_MCAST = 15;

  // configuration word map
  localparam int WORD_STA_LO    = 0;
  localparam int WORD_STA_HI    = 1;
  localparam int WORD_HASH_BASE = 2;
  localparam int WORD_MODE      = 4;

  typedef struct packed {
    logic bcast;
    logic phys;
    logic mcast;
  } addr_class_t;

  function automatic logic [CRC_W-1:0] crc_be_byte(input logic [CRC_W-1:0] crc_in,
                                                   input logic [7:0] data);
    logic [CRC_W-1:0] c;
    logic fb;
    c = crc_in;
    for (int b = 0; b < 8; b++) begin
      fb = c[CRC_W-1] ^ data[b];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = (c ^ CRC_TAIL) | {{(CRC_W-1){1'b0}}, 1'b1};
    end
    return c;
  endfunction

endpackage

// File: rtl/raf_cfg_regs.sv
module raf_cfg_regs
  import raf_pkg::*;
#(
  parameter int CFG_AW    = 3,
  parameter int CFG_DW    = 32,
  parameter int STATION_W = 48,
  parameter int HASH_SIZE = 64,
  parameter int MODE_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [CFG_DW-1:0]    cfg_wdata,
  output logic [STATION_W-1:0] station,
  output logic [HASH_SIZE-1:0] hash_tbl,
  output logic [MODE_W-1:0]    mode
);

  localparam int STA_HI_W   = STATION_W - CFG_DW;
  localparam int HASH_WORDS = HASH_SIZE / CFG_DW;

  logic [STATION_W-1:0] sta_q, sta_d;
  logic [HASH_SIZE-1:0] hash_q, hash_d;
  logic [MODE_W-1:0]    mode_q, mode_d;

  always_comb begin
    sta_d  = sta_q;
    hash_d = hash_q;
    mode_d = mode_q;
    if (cfg_addr == CFG_AW'(WORD_STA_LO))
      sta_d[CFG_DW-1:0] = cfg_wdata;
    if (cfg_addr == CFG_AW'(WORD_STA_HI))
      sta_d[STATION_W-1:CFG_DW] = cfg_wdata[STA_HI_W-1:0];
    for (int w = 0; w < HASH_WORDS; w++) begin
      if (cfg_addr == CFG_AW'(WORD_HASH_BASE + w))
        hash_d[w*CFG_DW +: CFG_DW] = cfg_wdata;
    end
    if (cfg_addr == CFG_AW'(WORD_MODE))
      mode_d = cfg_wdata[MODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_q  <= '0;
      hash_q <= '0;
      mode_q <= '0;
    end else if (cfg_we) begin
      sta_q  <= sta_d;
      hash_q <= hash_d;
      mode_q <= mode_d;
    end
  end

  assign station  = sta_q;
  assign hash_tbl = hash_q;
  assign mode     = mode_q;

endmodule

// File: rtl/raf_crc_hash.sv
module raf_crc_hash
  import raf_pkg::*;
#(
  parameter int HASH_IDX_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic                  first,
  input  logic [7:0]            data,
  output logic [HASH_IDX_W-1:0] hash_idx_next
);

  logic [CRC_W-1:0] crc_q, crc_d, crc_seed;

  always_comb begin
    crc_seed = first ? '1 : crc_q;
    crc_d    = crc_be_byte(crc_seed, data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= '1;
    else if (take) crc_q <= crc_d;
  end

  assign hash_idx_next = crc_d[CRC_W-1 -: HASH_IDX_W];

endmodule

// File: rtl/raf_addr_classify.sv
module raf_addr_classify
  import raf_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    byte_valid,
  input  logic                    byte_first,
  input  logic [7:0]              byte_data,
  input  logic [ADDR_BYTES*8-1:0] station,
  output logic                    take,
  output logic                    last_byte,
  output addr_class_t             cls_next
);

  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] POS_DONE = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] POS_LAST = CNT_W'(ADDR_BYTES - 1);

  logic [7:0]       st_bytes [ADDR_BYTES];
  logic [7:0]       st_sel;
  logic [CNT_W-1:0] cnt_q, cnt_d, pos;
  logic             phys_q, phys_d;
  logic             ones_q, ones_d;
  logic             grp_q, grp_d;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_sta_byte
    assign st_bytes[g] = station[g*8 +: 8];
  end

  always_comb begin
    pos  = byte_first ? '0 : cnt_q;
    take = byte_valid && (byte_first || (cnt_q != POS_DONE));
    st_sel = '0;
    for (int g = 0; g < ADDR_BYTES; g++) begin
      if (pos == CNT_W'(g)) st_sel = st_bytes[g];
    end
    cnt_d  = take ? pos + 1'b1 : cnt_q;
    phys_d = (byte_first ? 1'b1 : phys_q) & (byte_data == st_sel);
    ones_d = (byte_first ? 1'b1 : ones_q) & (byte_data == 8'hFF);
    grp_d  = byte_first ? byte_data[0] : grp_q;
    last_byte = take && (pos == POS_LAST);
    cls_next.bcast = ones_d;
    cls_next.phys  = phys_d;
    cls_next.mcast = grp_d & ~ones_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= POS_DONE;
      phys_q <= 1'b0;
      ones_q <= 1'b0;
      grp_q  <= 1'b0;
    end else if (take) begin
      cnt_q  <= cnt_d;
      phys_q <= phys_d;
      ones_q <= ones_d;
      grp_q  <= grp_d;
    end
  end

endmodule

// File: rtl/raf_rx_addr_filter.sv
module raf_rx_addr_filter
  import raf_pkg::*;
#(
  parameter int CFG_AW     = 3,
  parameter int CFG_DW     = 32,
  parameter int ADDR_BYTES = 6,
  parameter int HASH_IDX_W = 6,
  parameter int MODE_W     = 4,
  parameter int STATUS_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [CFG_DW-1:0]     cfg_wdata,
  input  logic                  rx_byte_valid,
  input  logic                  rx_byte_first,
  input  logic [7:0]            rx_byte,
  output logic                  dec_valid,
  output logic                  dec_accept,
  output logic [STATUS_W-1:0]   dec_status,
  output logic [HASH_IDX_W-1:0] dec_hash_idx
);

  localparam int STATION_W = ADDR_BYTES * 8;
  localparam int HASH_SIZE = 1 << HASH_IDX_W;

  logic [STATION_W-1:0]  station;
  logic [HASH_SIZE-1:0]  hash_tbl;
  logic [MODE_W-1:0]     accept_mode;
  logic                  take, last_byte, hash_hit;
  addr_class_t           cls_next;
  logic [HASH_IDX_W-1:0] idx_next;

  logic                  valid_q;
  logic                  accept_q, accept_d;
  logic [STATUS_W-1:0]   status_q, status_d;
  logic [HASH_IDX_W-1:0] idx_q;

  raf_cfg_regs #(
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .STATION_W(STATION_W),
    .HASH_SIZE(HASH_SIZE), .MODE_W(MODE_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .station(station), .hash_tbl(hash_tbl),
    .mode(accept_mode)
  );

  raf_addr_classify #(.ADDR_BYTES(ADDR_BYTES)) u_cls (
    .clk(clk), .rst_n(rst_n), .byte_valid(rx_byte_valid),
    .byte_first(rx_byte_first), .byte_data(rx_byte), .station(station),
    .take(take), .last_byte(last_byte), .cls_next(cls_next)
  );

  raf_crc_hash #(.HASH_IDX_W(HASH_IDX_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .take(take), .first(rx_byte_first),
    .data(rx_byte), .hash_idx_next(idx_next)
  );

  always_comb begin
    hash_hit = hash_tbl[idx_next];
    accept_d = accept_mode[MODE_PROMISC]
             | (accept_mode[MODE_PHYS]  & cls_next.phys)
             | (accept_mode[MODE_MCAST] & cls_next.mcast & hash_hit)
             | (accept_mode[MODE_BCAST] & cls_next.bcast);
    status_d = '0;
    status_d[ST_BCAST] = cls_next.bcast;
    status_d[ST_PHYS]  = cls_next.phys;
    status_d[ST_MCAST] = cls_next.mcast;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= last_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept_q <= 1'b0;
      status_q <= '0;
      idx_q    <= '0;
    end else if (last_byte) begin
      accept_q <= accept_d;
      status_q <= status_d;
      idx_q    <= idx_next;
    end
  end

  assign dec_valid    = valid_q;
  assign dec_accept   = accept_q;
  assign dec_status   = status_q;
  assign dec_hash_idx = idx_q;

endmodule

// File: rtl/raf_filter_checker.sv
module raf_filter_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        byte_valid,
  input logic        dec_valid,
  input logic        dec_accept,
  input logic [15:0] dec_status,
  input logic [3:0]  mode
);

  assert_valid_after_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(byte_valid));

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  assert_class_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !(dec_status[13] && dec_status[15]));

  assert_flag_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> ($countones(dec_status) <= 2));

  assert_promisc_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(mode[0])) |-> dec_accept);

  assert_bcast_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_status[13] && $past(mode[3])) |-> dec_accept);

  assert_phys_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_status[14] && $past(mode[1])) |-> dec_accept);

  assert_unclassified_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && (dec_status[15:13] == 3'b000) && !$past(mode[0])) |-> !dec_accept);

endmodule

bind raf_rx_addr_filter raf_filter_checker u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(rx_byte_valid),
  .dec_valid(dec_valid), .dec_accept(dec_accept),
  .dec_status(dec_status), .mode(accept_mode)
);

// File: tb/tb_raf_rx_addr_filter.sv
module tb_raf_rx_addr_filter;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        rx_byte_valid, rx_byte_first;
  logic [7:0]  rx_byte;
  logic        dec_valid, dec_accept;
  logic [15:0] dec_status;
  logic [5:0]  dec_hash_idx;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  localparam logic [47:0] STA   = 48'h5A_4B_3C_2D_1E_02;
  localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MC_A  = 48'h01_00_00_5E_00_01;
  localparam logic [47:0] MC_B  = 48'h77_66_55_44_33_03;
  localparam logic [47:0] OTHER = 48'h10_20_30_40_50_60;

  raf_rx_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_byte_valid(rx_byte_valid),
    .rx_byte_first(rx_byte_first), .rx_byte(rx_byte),
    .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_status(dec_status), .dec_hash_idx(dec_hash_idx)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 8; j++) begin
        fb = c[31] ^ a[i*8 + j];
        c = c << 1;
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    end
    return c[31:26];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_station(input logic [47:0] a);
    cfg_write(3'd0, a[31:0]);
    cfg_write(3'd1, {16'h0, a[47:32]});
  endtask

  // drives six bytes, with gap idle cycles between them; returns at the
  // negedge after the sixth byte was sampled (decision cycle)
  task automatic send_addr(input logic [47:0] a, input int gap);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      rx_byte_valid = 1'b1; rx_byte_first = (i == 0); rx_byte = a[i*8 +: 8];
      if (i < 5) begin
        for (int k = 0; k < gap; k++) begin
          @(negedge clk);
          rx_byte_valid = 1'b0; rx_byte_first = 1'b0;
          check("R9 no early decision", dec_valid, 0);
        end
      end
    end
    @(negedge clk);
    rx_byte_valid = 1'b0; rx_byte_first = 1'b0;
    check("R4 decision strobe", dec_valid, 1);
  endtask

  task automatic t_reset;
    check("R1 valid", dec_valid, 0);
    check("R1 accept", dec_accept, 0);
    check("R1 status", dec_status, 0);
    check("R1 hash idx", dec_hash_idx, 0);
  endtask

  task automatic t_unicast;
    set_station(STA);
    cfg_write(3'd4, 32'h2);
    send_addr(STA, 0);
    check("R6 phys accept", dec_accept, 1);
    check("R5 phys flag", dec_status, 16'h4000);
    @(negedge clk);
    check("R4 one cycle pulse", dec_valid, 0);
    check("R4 accept held", dec_accept, 1);
    send_addr(STA ^ 48'h01_00_00_00_00_00, 0);
    check("R6 phys mismatch reject", dec_accept, 0);
    check("R5 no flag", dec_status, 16'h0000);
    cfg_write(3'd4, 32'h0);
    send_addr(STA, 0);
    check("R6 phys bit off reject", dec_accept, 0);
    check("R5 phys flag still", dec_status, 16'h4000);
  endtask

  task automatic t_bad_cfg_addr;
    cfg_write(3'd4, 32'h2);
    cfg_write(3'd5, 32'hDEAD_BEEF);
    cfg_write(3'd6, 32'hFFFF_FFFF);
    cfg_write(3'd7, 32'h1234_5678);
    send_addr(STA, 0);
    check("R2 unused address no effect", dec_accept, 1);
    send_addr(OTHER, 0);
    check("R2 mode not changed", dec_accept, 0);
  endtask

  task automatic t_broadcast;
    cfg_write(3'd4, 32'h2);
    send_addr(BCAST, 0);
    check("R6 bcast bit off reject", dec_accept, 0);
    check("R5 bcast flag", dec_status, 16'h2000);
    cfg_write(3'd4, 32'h8);
    send_addr(BCAST, 1);
    check("R6 bcast accept", dec_accept, 1);
    check("R5 bcast flag gap", dec_status, 16'h2000);
    check("R3 bcast index", dec_hash_idx, ref_idx(BCAST));
  endtask

  task automatic t_multicast;
    logic [5:0] ia, ib;
    ia = ref_idx(MC_A);
    ib = ref_idx(MC_B);
    cfg_write(3'd2, 32'h0);
    cfg_write(3'd3, 32'h0);
    cfg_write(3'd4, 32'h4);
    send_addr(MC_A, 0);
    check("R3 hash index A", dec_hash_idx, ia);
    check("R6 empty table reject", dec_accept, 0);
    check("R5 mcast flag", dec_status, 16'h8000);
    if (ia < 32) cfg_write(3'd2, 32'h1 << ia);
    else         cfg_write(3'd3, 32'h1 << (ia - 32));
    send_addr(MC_A, 0);
    check("R3 hash bit hit accept", dec_accept, 1);
    send_addr(MC_B, 2);
    check("R3 hash index B", dec_hash_idx, ib);
    check("R3 other bit miss", dec_accept, (ib == ia) ? 1 : 0);
    cfg_write(3'd2, 32'h0);
    cfg_write(3'd3, 32'h0);
    if (ib < 32) cfg_write(3'd2, 32'h1 << ib);
    else         cfg_write(3'd3, 32'h1 << (ib - 32));
    send_addr(MC_B, 0);
    check("R2 hash word write accept", dec_accept, 1);
    cfg_write(3'd4, 32'h0);
    send_addr(MC_B, 0);
    check("R6 mcast bit off reject", dec_accept, 0);
  endtask

  task automatic t_promisc;
    cfg_write(3'd4, 32'h1);
    send_addr(OTHER, 0);
    check("R7 promisc accept", dec_accept, 1);
    check("R7 no class flag", dec_status, 16'h0000);
    send_addr(BCAST, 0);
    check("R7 promisc bcast flag", dec_status, 16'h2000);
    check("R7 promisc bcast accept", dec_accept, 1);
  endtask

  task automatic t_restart;
    cfg_write(3'd4, 32'h2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_byte_valid = 1'b1; rx_byte_first = (i == 0); rx_byte = 8'hC3;
    end
    send_addr(STA, 0);
    check("R8 restart accept", dec_accept, 1);
    check("R8 restart flag", dec_status, 16'h4000);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rx_byte_valid = 1'b1; rx_byte_first = 1'b0; rx_byte = 8'hFF;
      check("R8 surplus no decision", dec_valid, 0);
    end
    @(negedge clk);
    rx_byte_valid = 1'b0;
    check("R8 surplus no decision end", dec_valid, 0);
    check("R8 outputs held", dec_accept, 1);
    check("R8 status held", dec_status, 16'h4000);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    rx_byte_valid = 1'b0; rx_byte_first = 1'b0; rx_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unicast();
    t_bad_cfg_addr();
    t_broadcast();
    t_multicast();
    t_promisc();
    t_restart();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule